// File: doc/BRIEF.md
# Noise-Filtered External Event Counter

This block counts pulses that arrive on one of two external pins. The selected pin is first brought into the system clock domain by two flip-flops. It then passes through a sampled noise filter, whose sampling strobe is taken from a slow oscillator enable through a divider of 16 or 128. The filtered level drives an up counter, and a one-cycle interrupt request is raised each time the counter wraps to zero.

Counting starts and stops by gating the filter's sampling strobe with a run bit. While stopped, the filter holds its level, so the counter cannot move. Which pin is counted, which edge of it is counted, and the divide ratio are all fixed when the block is built, through parameters. A synchronous clear input resets the count, and the count is always visible on an output port.

Top module: `pulse_tally`

## Requirements
- R1: Out of reset, `count` is 0 and `irq` is 0.
- R2: With `SRC_SEL`=0, the block counts rising edges of the filtered `pin_a` and ignores `pin_b`. With `SRC_SEL`=1, it counts falling edges of the filtered `pin_b` and ignores `pin_a`.
- R3: The filter is sampled on a strobe that fires on every 16th `osc_tick` pulse accepted while `run_en` is 1 (`DIV_SLOW`=0), or on every 128th such pulse (`DIV_SLOW`=1). The divider phase counts from reset.
- R4: The filter takes a new level only after seeing it on two consecutive sample strobes. A pin level that is present at just one strobe never changes the count.
- R5: A pin level held across two consecutive strobes produces exactly one count, and the count follows within two clock cycles of the second strobe.
- R6: While `run_en` is 0, `osc_tick` pulses are ignored, the divider phase holds, and the count does not change whatever the pin does. Setting `run_en` back to 1 with the pin at its old level gives no count.
- R7: `cnt_clr` high sets `count` to 0 on the next clock edge, and it wins over an increment in the same cycle.
- R8: `irq` goes high for exactly one cycle, in the same cycle that `count` goes from all ones to 0.
- R9: `irq` stays 0 at every other time, including all counts below the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle enable at the slow oscillator rate |
| pin_a | input | 1 | Candidate pin counted on rising edges (asynchronous) |
| pin_b | input | 1 | Candidate pin counted on falling edges (asynchronous) |
| run_en | input | 1 | 1 runs the sample strobe, 0 stops it |
| cnt_clr | input | 1 | Synchronous clear of the count |
| count | output | COUNT_W | Current count value |
| irq | output | 1 | One-cycle pulse when the count wraps |

## Verification
The assertions assume that `osc_tick` is a one-cycle enable and that the strobe arrives only through the divider. The stimulus drives `osc_tick` as a single high cycle at a negative edge, followed by a low cycle. The assertions also assume that pin edges reach the filter only through the synchronizer. The stimulus therefore changes a pin and waits four clock cycles before it issues any sample strobe, so every sample sees a settled level. Strobes are issued in whole groups of 16 `osc_tick` pulses, except in the divider test, so the bench always knows the divider phase when it predicts a count.

// File: rtl/pt_pkg.sv
package pt_pkg;

  // which edge of the filtered level advances the counter
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;

  // divide ratio of the sampling strobe prescaler
  function automatic int unsigned div_ratio(input bit slow);
    return slow ? 128 : 16;
  endfunction

  function automatic edge_kind_e edge_of_source(input bit src_sel);
    return src_sel ? EDGE_FALL : EDGE_RISE;
  endfunction

endpackage

// File: rtl/pt_prescale.sv
module pt_prescale #(
  parameter bit DIV_SLOW = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic run_en,
  output logic fch_tick
);
  localparam int unsigned DIV = pt_pkg::div_ratio(DIV_SLOW);
  localparam int unsigned PW  = $clog2(DIV);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;
  logic          step_ok;

  assign step_ok  = osc_tick && run_en;
  assign fch_tick = step_ok && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (fch_tick) phase_q <= '0;
    else if (step_ok)  phase_q <= phase_q + 1'b1;
  end

  // R6: the divider phase is frozen while stopped
  p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(phase_q));

  // R3: a strobe needs a running, ticking oscillator
  p_tick_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fch_tick |-> (run_en && osc_tick));

endmodule

// File: rtl/pt_denoise.sv
module pt_denoise (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  input  logic fch_tick,
  output logic lvl_rise,
  output logic lvl_fall
);
  logic [1:0] sync_q;
  logic       pin_s;
  logic       prev_q;
  logic       stable_q;
  logic       confirm;

  assign pin_s   = sync_q[1];
  assign confirm = fch_tick && (pin_s == prev_q) && (pin_s != stable_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], pin_raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      stable_q <= 1'b0;
      lvl_rise <= 1'b0;
      lvl_fall <= 1'b0;
    end else begin
      lvl_rise <= 1'b0;
      lvl_fall <= 1'b0;
      if (fch_tick) prev_q <= pin_s;
      if (confirm) begin
        stable_q <= pin_s;
        lvl_rise <= pin_s;
        lvl_fall <= !pin_s;
      end
    end
  end

  // R4: the filtered level moves only right after a sample strobe
  p_level_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stable_q) |-> $past(fch_tick));

  // R4: an accepted level equals the previous sample
  p_two_samples_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stable_q) |-> (stable_q == $past(prev_q)));

  p_edge_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(lvl_rise && lvl_fall));

endmodule

// File: rtl/pt_tally.sv
module pt_tally #(
  parameter int unsigned COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               bump,
  output logic [COUNT_W-1:0] count,
  output logic               wrap_irq
);
  localparam logic [COUNT_W-1:0] TOP = '1;

  function automatic logic [COUNT_W-1:0] step(input logic [COUNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic logic at_top(input logic [COUNT_W-1:0] c);
    return c == TOP;
  endfunction

  logic do_inc;
  assign do_inc = bump && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      wrap_irq <= 1'b0;
    end else begin
      wrap_irq <= do_inc && at_top(count);
      if (clr)         count <= '0;
      else if (do_inc) count <= step(count);
    end
  end

  // R7: a clear always wins
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  // R5: an accepted edge without clear moves the count by one
  p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !clr) |=> (count == $past(count) + 1'b1));

  // R6: without edge or clear the count holds
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bump && !clr) |=> $stable(count));

  // R8: interrupt only on a wrap to zero
  p_irq_at_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_irq |-> ((count == '0) && ($past(count) == TOP)));

  // R8: interrupt lasts one cycle
  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_irq |=> !wrap_irq);

endmodule

// File: rtl/pulse_tally.sv
module pulse_tally #(
  parameter bit          SRC_SEL  = 1'b0,
  parameter bit          DIV_SLOW = 1'b1,
  parameter int unsigned COUNT_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               osc_tick,
  input  logic               pin_a,
  input  logic               pin_b,
  input  logic               run_en,
  input  logic               cnt_clr,
  output logic [COUNT_W-1:0] count,
  output logic               irq
);
  import pt_pkg::*;

  localparam edge_kind_e EDGE = edge_of_source(SRC_SEL);

  logic pin_sel;
  logic fch_tick;
  logic lvl_rise;
  logic lvl_fall;
  logic edge_hit;

  assign pin_sel  = (EDGE == EDGE_FALL) ? pin_b : pin_a;
  assign edge_hit = (EDGE == EDGE_FALL) ? lvl_fall : lvl_rise;

  pt_prescale #(.DIV_SLOW(DIV_SLOW)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .run_en   (run_en),
    .fch_tick (fch_tick)
  );

  pt_denoise u_flt (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_raw  (pin_sel),
    .fch_tick (fch_tick),
    .lvl_rise (lvl_rise),
    .lvl_fall (lvl_fall)
  );

  pt_tally #(.COUNT_W(COUNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .bump     (edge_hit),
    .count    (count),
    .wrap_irq (irq)
  );

  // R6: no count edge can appear while stopped, once the pipeline drains
  p_stopped_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !$past(run_en)) |-> !edge_hit);

  // R9: interrupt needs an edge in the cycle before
  p_irq_needs_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(edge_hit));

endmodule

// File: tb/sim_pulse_tally.sv
`timescale 1ns/1ps
module sim_pulse_tally;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic pin_a = 1'b0;
  logic pin_b = 1'b1;
  logic run_en = 1'b1;
  logic cnt_clr = 1'b0;
  logic [7:0] cnt0, cnt1;
  logic irq0, irq1;

  int vectors = 0;
  int miscompares = 0;
  int irq_hits = 0;
  int irq_long = 0;
  logic irq_prev = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pulse_tally #(.SRC_SEL(1'b0), .DIV_SLOW(1'b0), .COUNT_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pin_a(pin_a), .pin_b(pin_b),
    .run_en(run_en), .cnt_clr(cnt_clr), .count(cnt0), .irq(irq0));

  pulse_tally #(.SRC_SEL(1'b1), .DIV_SLOW(1'b0), .COUNT_W(8)) u1 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pin_a(pin_a), .pin_b(pin_b),
    .run_en(run_en), .cnt_clr(cnt_clr), .count(cnt1), .irq(irq1));

  always @(posedge clk) begin
    if (rst_n) begin
      if (irq0) irq_hits++;
      if (irq0 && irq_prev) irq_long++;
      irq_prev <= irq0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d, expected %0d", req, act, exp);
    end
  endtask

  task automatic osc_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) osc_tick = 1'b1;
      @(negedge clk) osc_tick = 1'b0;
    end
  endtask

  task automatic strobes(input int n);
    osc_pulses(16 * n);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_a();
    pin_a = 1'b1; settle(); strobes(2);
    pin_a = 1'b0; settle(); strobes(2); settle();
  endtask

  task automatic t_reset();
    chk("R1 count after reset", cnt0, 0);
    chk("R1 irq after reset", irq0, 0);
    chk("R1 second unit count after reset", cnt1, 0);
    // pin_b idles high: the second unit learns that level (a rise, not counted)
    strobes(2); settle();
    chk("R2 rise on pin_b ignored by falling unit", cnt1, 0);
  endtask

  task automatic t_single();
    pin_a = 1'b1; settle(); strobes(2); settle();
    chk("R5 count follows second strobe", cnt0, 1);
    chk("R2 pin_a ignored by falling unit", cnt1, 0);
    pin_a = 1'b0; settle(); strobes(2); settle();
    chk("R2 falling edge of pin_a not counted", cnt0, 1);
  endtask

  task automatic t_divider();
    pin_a = 1'b1; settle();
    osc_pulses(31); settle();
    chk("R3 no count before 32nd oscillator pulse", cnt0, 1);
    osc_pulses(1); settle();
    chk("R3 count at 32nd oscillator pulse", cnt0, 2);
    pin_a = 1'b0; settle(); strobes(2); settle();
  endtask

  task automatic t_noise();
    for (int k = 0; k < 3; k++) begin
      pin_a = 1'b1; settle(); strobes(1);
      pin_a = 1'b0; settle(); strobes(2); settle();
    end
    chk("R4 one-strobe pulses rejected", cnt0, 2);
  endtask

  task automatic t_stop();
    run_en = 1'b0;
    pin_a = 1'b1; settle(); osc_pulses(64); settle();
    chk("R6 no count while stopped", cnt0, 2);
    pin_a = 1'b0; settle(); osc_pulses(64);
    run_en = 1'b1; strobes(2); settle();
    chk("R6 no false count on resume", cnt0, 2);
    pulse_a();
    chk("R6 counting resumes in phase", cnt0, 3);
  endtask

  task automatic t_falling();
    pin_b = 1'b0; settle(); strobes(2); settle();
    chk("R2 falling edge of pin_b counted", cnt1, 1);
    pin_b = 1'b1; settle(); strobes(2); settle();
    chk("R2 rising edge of pin_b not counted", cnt1, 1);
    chk("R2 pin_b ignored by rising unit", cnt0, 3);
  endtask

  task automatic t_clear();
    @(negedge clk) cnt_clr = 1'b1;
    pin_a = 1'b1; settle(); strobes(2); settle();
    @(negedge clk) cnt_clr = 1'b0;
    chk("R7 clear beats increment", cnt0, 0);
    pin_a = 1'b0; settle(); strobes(2); settle();
    chk("R7 stays clear", cnt0, 0);
  endtask

  task automatic t_wrap();
    irq_hits = 0;
    irq_long = 0;
    for (int k = 0; k < 255; k++) pulse_a();
    chk("R9 count reaches all ones", cnt0, 255);
    chk("R9 no interrupt before wrap", irq_hits, 0);
    pulse_a();
    chk("R8 count wraps to zero", cnt0, 0);
    chk("R8 one interrupt at wrap", irq_hits, 1);
    chk("R8 interrupt one cycle wide", irq_long, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_divider();
    t_noise();
    t_stop();
    t_falling();
    t_clear();
    t_wrap();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule